// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned N-bit numbers over several clock cycles and returns the exact 2N-bit result. A pulse on `start` while the unit is idle captures both operands and clears the result register. The unit then runs one step per clock. In each step, the multiplicand is added to the running result when the low bit of the multiplier is set. On the same edge the multiplicand moves one place towards the high end and the multiplier moves one place towards the low end.

The loop length depends on the data. Work ends on the step that leaves the multiplier register empty, so the number of steps equals the position of the multiplier's highest set bit plus one. A zero multiplier needs no step at all. `done` pulses for one cycle when the result is final, and `product` then holds its value until the next accepted start.

Top module: `shift_add_multiplier`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all 0.
- R2: A `start` sampled high while `busy` is 0 captures `mcand_in` and `mplier_in`. From the next cycle on, `product` reads 0 until the first step has been taken.
- R3: During an operation, after j steps `product` equals A × (B mod 2^j), where A and B are the captured operands.
- R4: The multiplicand is held zero-extended to 2N bits, so no bit is lost across the shifts. For example, 255 × 255 gives 65025 when N = 8.
- R5: For a nonzero multiplier B, `busy` is high for exactly L cycles, where L is the index of B's highest set bit plus one (1 ≤ L ≤ N).
- R6: For a zero multiplier, `busy` stays 0, `done` is high in the cycle after the start and `product` is 0.
- R7: A `start` sampled while `busy` is 1 has no effect on the operation in flight or on its result.
- R8: `done` is high for a single cycle per operation. `busy` is 0 while `done` is high, and `product` keeps its final value until the next accepted start.
- R9: When `done` is high, `product` equals the full 2N-bit product A × B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin; accepted only while idle |
| mcand_in | input | WIDTH | Multiplicand operand A |
| mplier_in | input | WIDTH | Multiplier operand B |
| busy | output | 1 | High while steps are being taken |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*WIDTH | Running and then final product |

## Verification
On every cycle the assertions check the following: the result never decreases during a step, it stays unchanged outside a step, the shifting multiplicand keeps its population count, `done` and `busy` are never high together, a completion pulse is not repeated without a new start, and a run never lasts more than N cycles. Only the bench's scenarios can show the exact values that the arithmetic produces. These cover the partial products after each step, the exact data-dependent run length for each highest-bit position, the zero-multiplier shortcut, and the fact that a start arriving mid-run leaves the first result unchanged. The bench's behavioural model predicts `busy`, `done` and `product` on every clock, and directed runs check the final values and cycle counts.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;
endpackage

// File: rtl/mul_datapath.sv
module mul_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic               opb_zero,
    output logic               last_step,
    output logic [2*WIDTH-1:0] product
);
    localparam int PW = 2 * WIDTH;

    typedef struct packed {
        logic [PW-1:0]    mcand;
        logic [WIDTH-1:0] mplier;
        logic [PW-1:0]    acc;
    } dp_regs_t;

    dp_regs_t r_d, r_q;
    logic [PW-1:0] addend;

    always_comb begin
        r_d    = r_q;
        addend = r_q.mplier[0] ? r_q.mcand : '0;
        if (load) begin
            r_d.mcand  = PW'(mcand_in);
            r_d.mplier = mplier_in;
            r_d.acc    = '0;
        end else if (step) begin
            r_d.acc    = r_q.acc + addend;
            r_d.mcand  = r_q.mcand << 1;
            r_d.mplier = r_q.mplier >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign opb_zero  = (mplier_in == '0);
    assign last_step = (r_q.mplier[WIDTH-1:1] == '0);
    assign product   = r_q.acc;

    // R3: a step only ever adds to the running result
    a_r3_acc_nondecreasing: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (r_q.acc >= $past(r_q.acc)));
    // R8: result is held whenever no load or step happens
    a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(r_q.acc));
    // R4: the left shift of the extended multiplicand loses no set bit
    a_r4_mcand_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ($countones(r_q.mcand) == $past($countones(r_q.mcand))));
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic opb_zero,
    input  logic last_step,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WIDTH + 1);

    typedef struct packed {
        mul_state_e state;
        logic       done;
    } ctrl_regs_t;

    ctrl_regs_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (opb_zero) c_d.done  = 1'b1;
                    else          c_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                step = 1'b1;
                if (last_step) begin
                    c_d.state = ST_IDLE;
                    c_d.done  = 1'b1;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{state: ST_IDLE, done: 1'b0};
        else        c_q <= c_d;
    end

    assign busy = (c_q.state == ST_RUN);
    assign done = c_q.done;

    // run-length counter used only by the bound check below
    logic [CW-1:0] run_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt_q <= '0;
        else if (busy) run_cnt_q <= run_cnt_q + 1'b1;
        else           run_cnt_q <= '0;
    end

    // R5: a run never needs more than WIDTH steps
    a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt_q < CW'(WIDTH)));
    // R8: completion and activity are exclusive
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8: no second pulse without a new start
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);
    // R2: a run only begins from a start request
    a_r2_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/shift_add_multiplier.sv
module shift_add_multiplier #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic load, step, opb_zero, last_step;

    mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opb_zero  (opb_zero),
        .last_step (last_step),
        .load      (load),
        .step      (step),
        .busy      (busy),
        .done      (done)
    );

    mul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .opb_zero  (opb_zero),
        .last_step (last_step),
        .product   (product)
    );

    // R7: no reload is taken while a run is in flight
    a_r7_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);
endmodule

// File: tb/sim_shift_add_multiplier.sv
module sim_shift_add_multiplier;
    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   a_in = '0;
    logic [W-1:0]   b_in = '0;
    logic           busy, done;
    logic [2*W-1:0] product;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    shift_add_multiplier #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mcand_in(a_in), .mplier_in(b_in),
        .busy(busy), .done(done), .product(product)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int bitlen(input longint v);
        int n = 0;
        for (int i = 0; i < 64; i++) if (v[i]) n = i + 1;
        return n;
    endfunction

    // behavioural reference model, advanced on each rising edge
    bit     m_busy, m_done;
    longint m_a, m_b, m_prod;
    int     m_j, m_len;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_prod = 0; m_j = 0; m_len = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_j++;
                m_prod = m_a * (m_b & ((longint'(1) << m_j) - 1));
                if (m_j == m_len) begin m_busy = 0; m_done = 1; end
            end else if (start) begin
                m_a = a_in; m_b = b_in; m_j = 0; m_prod = 0;
                if (b_in == 0) m_done = 1;
                else begin m_busy = 1; m_len = bitlen(b_in); end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R5/R7 busy", busy, m_busy);
            check("R8 done", done, m_done);
            check("R3 product", product, m_prod);
        end
    end

    task automatic run_op(input longint a, input longint b, input int inject_at);
        int n = 0;
        int guard = 0;
        a_in = W'(a); b_in = W'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (b != 0) check("R2 product cleared", product, 0);
        while (!done && guard < 100) begin
            if (busy) n++;
            if (inject_at > 0 && n == inject_at) begin
                start = 1'b1; a_in = 8'hA5; b_in = 8'h3C;
            end
            @(negedge clk);
            start = 1'b0;
            guard++;
        end
        check("R5 run length", n, bitlen(b));
        check("R9 final product", product, a * b);
        if (b == 0) check("R6 zero multiplier", product, 0);
        if (inject_at > 0) check("R7 start while busy ignored", product, a * b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy at reset", busy, 0);
        check("R1 done at reset", done, 0);
        check("R1 product at reset", product, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(4, 3, 0);
        run_op(13, 11, 0);
        run_op(255, 255, 0);                 // R4 full-width result
        check("R4 wide result", product, 65025);
        run_op(8'h80, 8'hFF, 0);
        run_op(1, 8'h80, 0);                 // R5 longest run
        run_op(200, 1, 0);                   // R5 shortest run
        run_op(77, 0, 0);                    // R6
        run_op(0, 99, 0);
        run_op(37, 8'hC4, 3);                // R7

        // R8: result held while idle and no start
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 product hold", product, 37 * 8'hC4);
            check("R8 done low", done, 0);
        end

        // back-to-back: new start in the done cycle
        run_op(9, 6, 0);
        run_op(15, 15, 0);
        for (int k = 1; k < 40; k++) run_op((k * 37) % 256, (k * 91) % 256, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule